// File: doc/BRIEF.md
# Clock-Gating and Module Activation Controller

This block is a register-mapped system controller that decides which peripheral modules of a chip receive a clock and which are held active. It keeps two control vectors with one bit per module: clock enable and activation. Software changes single bits with write-one-to-set and write-one-to-clear offsets, so no read-modify-write is needed. Bits written as zero are left as they are. Each status bit follows its control bit only after a programmable settle time. Software writes a command and then polls a status register until the masked bits match.

A reboot offset briefly drops the reported activation of modules that are already active while their activation control is kept. The block also drives a host reset output level and a CPU clock half-rate select bit. Each status bit is tracked by a small state machine with three states: `SET_HOLD`, `SET_WAIT` and `SET_FORCE`.
- In `SET_HOLD` the bit is settled.
- A command moves `SET_HOLD` to `SET_WAIT`, and the counter starts from zero. A further command while in `SET_WAIT` restarts the count.
- A reboot moves any state to `SET_FORCE`, and the status is driven low.
- When the counter reaches the settle count, `SET_WAIT` or `SET_FORCE` goes back to `SET_HOLD`, and the status takes the current control value.

Several peripherals may share one activation bit; a single write acts on every one of them.

Top module: `modgate_ctrl`

## Requirements
- R1: After reset, both control vectors, both status vectors, `hrst_o` and `cpu_half_o` are zero, and every readable offset returns zero.
- R2: Writing offset 0x04 sets the clock-enable bits where the data has ones, and writing offset 0x08 clears them. Zero data bits leave their bits unchanged. Reading 0x04 returns the clock-enable vector, zero-extended to 32 bits.
- R3: The clock status read at 0x00 changes exactly SETTLE clock edges after the edge that accepted the write. It then equals the clock-enable bit.
- R4: Writing offset 0x24 sets the activation control bits where the data has ones, and writing offset 0x28 clears them. Reading 0x24 returns the activation control vector.
- R5: The activation status read at 0x20 is the settled activation bit ANDed with the settled clock status bit of the same module.
- R6: A further set or clear write that touches a bit while that bit is still settling restarts its settle count. The status then changes SETTLE edges after the latest write.
- R7: Writing ones to offset 0x2C acts on the modules whose activation control bit is set. Their activation status reads 0 from the accepting edge until SETTLE edges later, and then reads active again. Modules that are not activated and the activation control vector are not affected.
- R8: Writing offset 0xC0 sets `hrst_o` to data bit 0 at the accepting edge. Reading 0xC0 returns that level in bit 0.
- R9: Writing offset 0x40 sets `cpu_half_o` (1 = half-rate CPU clock) to data bit 0. Reading 0x40 returns that bit in bit 0.
- R10: Unmapped offsets read zero, and writes to them change nothing. The write-only offsets 0x08, 0x28 and 0x2C read zero. Bits at and above NUM_MOD read zero. `rdata_o` is zero while `rd_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Byte offset of the access |
| wdata_i | input | 32 | Write data |
| wr_i | input | 1 | Write strobe, one cycle per write |
| rd_i | input | 1 | Read strobe; read data is valid in the same cycle |
| rdata_o | output | 32 | Read data |
| clk_en_o | output | NUM_MOD | Clock-enable control vector to the gating cells |
| act_en_o | output | NUM_MOD | Activation control vector |
| clk_stat_o | output | NUM_MOD | Settled clock status |
| act_stat_o | output | NUM_MOD | Activation status (settled activation AND settled clock) |
| hrst_o | output | 1 | Host reset output level |
| cpu_half_o | output | 1 | CPU clock half-rate select |

## Verification
The assertions assume these things about the inputs:
- `wr_i` and `rd_i` are never high in the same cycle.
- A write lasts a single cycle.
- A set, clear and reboot command never reach the same bit on the same edge.

Because of the last point, the settle machine can give reboot priority without losing a command. The bench drives every access through one task per strobe. Each task raises exactly one strobe for one cycle, with inputs changed one time unit after the rising edge, so the stimulus never breaks these assumptions.

// File: rtl/modgate_pkg.sv
package modgate_pkg;

    // Register offsets: the controller's behaviour is keyed on these values
    localparam logic [7:0] OFS_CLK_STAT = 8'h00;
    localparam logic [7:0] OFS_CLK_SET  = 8'h04;
    localparam logic [7:0] OFS_CLK_CLR  = 8'h08;
    localparam logic [7:0] OFS_ACT_STAT = 8'h20;
    localparam logic [7:0] OFS_ACT_SET  = 8'h24;
    localparam logic [7:0] OFS_ACT_CLR  = 8'h28;
    localparam logic [7:0] OFS_REBOOT   = 8'h2C;
    localparam logic [7:0] OFS_CPU_CLK  = 8'h40;
    localparam logic [7:0] OFS_HRST     = 8'hC0;

    // Per-bit settle machine states
    typedef enum logic [1:0] {
        SET_HOLD  = 2'd0,
        SET_WAIT  = 2'd1,
        SET_FORCE = 2'd2
    } settle_state_e;

    // One-hot write decode
    typedef struct packed {
        logic clk_set;
        logic clk_clr;
        logic act_set;
        logic act_clr;
        logic reboot;
        logic cpu;
        logic hrst;
    } wr_dec_t;

endpackage

// File: rtl/modgate_settle_bit.sv
module modgate_settle_bit
    import modgate_pkg::*;
#(
    parameter int SETTLE = 6,
    localparam int CNT_W = (SETTLE < 2) ? 1 : $clog2(SETTLE + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tgt_i,
    input  logic kick_i,
    input  logic force_i,
    output logic stat_o
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE - 1);

    settle_state_e state, state_nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;
    logic finish;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SET_HOLD;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    // Transitions
    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        finish    = 1'b0;
        unique case (state)
            SET_HOLD: begin
                if (force_i) begin
                    state_nxt = SET_FORCE;
                    cnt_nxt   = '0;
                end else if (kick_i) begin
                    state_nxt = SET_WAIT;
                    cnt_nxt   = '0;
                end
            end
            SET_WAIT, SET_FORCE: begin
                if (force_i) begin
                    state_nxt = SET_FORCE;
                    cnt_nxt   = '0;
                end else if (kick_i) begin
                    state_nxt = SET_WAIT;
                    cnt_nxt   = '0;
                end else if (cnt == LAST) begin
                    state_nxt = SET_HOLD;
                    cnt_nxt   = '0;
                    finish    = 1'b1;
                end else begin
                    cnt_nxt = cnt + CNT_W'(1);
                end
            end
            default: begin
                state_nxt = SET_HOLD;
                cnt_nxt   = '0;
            end
        endcase
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            stat_o <= 1'b0;
        else if (force_i)
            stat_o <= 1'b0;
        else if (finish)
            stat_o <= tgt_i;
    end

    // R3
    settle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SET_HOLD && !kick_i && !force_i) |=> $stable(stat_o));

    // R7
    force_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_i |=> !stat_o);

    // R6
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

endmodule

// File: rtl/modgate_settle_vec.sv
module modgate_settle_vec #(
    parameter int NUM_MOD = 24,
    parameter int SETTLE  = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_MOD-1:0] tgt_i,
    input  logic [NUM_MOD-1:0] kick_i,
    input  logic [NUM_MOD-1:0] force_i,
    output logic [NUM_MOD-1:0] stat_o
);

    for (genvar g = 0; g < NUM_MOD; g++) begin : g_bit
        modgate_settle_bit #(.SETTLE(SETTLE)) i_bit (
            .clk     (clk),
            .rst_n   (rst_n),
            .tgt_i   (tgt_i[g]),
            .kick_i  (kick_i[g]),
            .force_i (force_i[g]),
            .stat_o  (stat_o[g])
        );
    end

endmodule

// File: rtl/modgate_regs.sv
module modgate_regs
    import modgate_pkg::*;
#(
    parameter int NUM_MOD = 24,
    parameter int ADDR_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [31:0]        wdata_i,
    input  logic               wr_i,
    input  logic               rd_i,
    input  logic [NUM_MOD-1:0] clk_stat_i,
    input  logic [NUM_MOD-1:0] act_stat_i,
    output logic [31:0]        rdata_o,
    output logic [NUM_MOD-1:0] clk_ctl_o,
    output logic [NUM_MOD-1:0] act_ctl_o,
    output logic [NUM_MOD-1:0] clk_kick_o,
    output logic [NUM_MOD-1:0] act_kick_o,
    output logic [NUM_MOD-1:0] rbt_o,
    output logic               hrst_o,
    output logic               cpu_half_o
);

    wr_dec_t dec;
    logic [NUM_MOD-1:0] wbits;
    logic unused_hi;

    assign wbits     = wdata_i[NUM_MOD-1:0];
    assign unused_hi = ^wdata_i[31:NUM_MOD];

    always_comb begin
        dec         = '0;
        dec.clk_set = wr_i && (addr_i == ADDR_W'(OFS_CLK_SET));
        dec.clk_clr = wr_i && (addr_i == ADDR_W'(OFS_CLK_CLR));
        dec.act_set = wr_i && (addr_i == ADDR_W'(OFS_ACT_SET));
        dec.act_clr = wr_i && (addr_i == ADDR_W'(OFS_ACT_CLR));
        dec.reboot  = wr_i && (addr_i == ADDR_W'(OFS_REBOOT));
        dec.cpu     = wr_i && (addr_i == ADDR_W'(OFS_CPU_CLK));
        dec.hrst    = wr_i && (addr_i == ADDR_W'(OFS_HRST));
    end

    assign clk_kick_o = (dec.clk_set || dec.clk_clr) ? wbits : '0;
    assign act_kick_o = (dec.act_set || dec.act_clr) ? wbits : '0;
    assign rbt_o      = dec.reboot ? (wbits & act_ctl_o) : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_ctl_o  <= '0;
            act_ctl_o  <= '0;
            hrst_o     <= 1'b0;
            cpu_half_o <= 1'b0;
        end else begin
            if (dec.clk_set) clk_ctl_o <= clk_ctl_o | wbits;
            if (dec.clk_clr) clk_ctl_o <= clk_ctl_o & ~wbits;
            if (dec.act_set) act_ctl_o <= act_ctl_o | wbits;
            if (dec.act_clr) act_ctl_o <= act_ctl_o & ~wbits;
            if (dec.hrst)    hrst_o     <= wdata_i[0];
            if (dec.cpu)     cpu_half_o <= wdata_i[0];
        end
    end

    always_comb begin
        rdata_o = '0;
        if (rd_i) begin
            unique case (addr_i)
                ADDR_W'(OFS_CLK_STAT): rdata_o = 32'(clk_stat_i);
                ADDR_W'(OFS_CLK_SET):  rdata_o = 32'(clk_ctl_o);
                ADDR_W'(OFS_ACT_STAT): rdata_o = 32'(act_stat_i);
                ADDR_W'(OFS_ACT_SET):  rdata_o = 32'(act_ctl_o);
                ADDR_W'(OFS_CPU_CLK):  rdata_o = {31'd0, cpu_half_o};
                ADDR_W'(OFS_HRST):     rdata_o = {31'd0, hrst_o};
                default:               rdata_o = '0;
            endcase
        end
    end

    // R2
    clk_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec.clk_set |=> ((clk_ctl_o & $past(wbits)) == $past(wbits)));

    // R2
    clk_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec.clk_clr |=> ((clk_ctl_o & $past(wbits)) == '0));

    // R4
    act_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec.act_set && !dec.act_clr) |=> $stable(act_ctl_o));

    // R8
    hrst_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec.hrst |=> (hrst_o == $past(wdata_i[0])));

endmodule

// File: rtl/modgate_ctrl.sv
module modgate_ctrl #(
    parameter int NUM_MOD = 24,
    parameter int SETTLE  = 6,
    parameter int ADDR_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [31:0]        wdata_i,
    input  logic               wr_i,
    input  logic               rd_i,
    output logic [31:0]        rdata_o,
    output logic [NUM_MOD-1:0] clk_en_o,
    output logic [NUM_MOD-1:0] act_en_o,
    output logic [NUM_MOD-1:0] clk_stat_o,
    output logic [NUM_MOD-1:0] act_stat_o,
    output logic               hrst_o,
    output logic               cpu_half_o
);

    logic [NUM_MOD-1:0] clk_kick, act_kick, rbt, act_settled, no_force;

    assign no_force = '0;

    modgate_regs #(.NUM_MOD(NUM_MOD), .ADDR_W(ADDR_W)) i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_i     (addr_i),
        .wdata_i    (wdata_i),
        .wr_i       (wr_i),
        .rd_i       (rd_i),
        .clk_stat_i (clk_stat_o),
        .act_stat_i (act_stat_o),
        .rdata_o    (rdata_o),
        .clk_ctl_o  (clk_en_o),
        .act_ctl_o  (act_en_o),
        .clk_kick_o (clk_kick),
        .act_kick_o (act_kick),
        .rbt_o      (rbt),
        .hrst_o     (hrst_o),
        .cpu_half_o (cpu_half_o)
    );

    modgate_settle_vec #(.NUM_MOD(NUM_MOD), .SETTLE(SETTLE)) i_clk_settle (
        .clk     (clk),
        .rst_n   (rst_n),
        .tgt_i   (clk_en_o),
        .kick_i  (clk_kick),
        .force_i (no_force),
        .stat_o  (clk_stat_o)
    );

    modgate_settle_vec #(.NUM_MOD(NUM_MOD), .SETTLE(SETTLE)) i_act_settle (
        .clk     (clk),
        .rst_n   (rst_n),
        .tgt_i   (act_en_o),
        .kick_i  (act_kick),
        .force_i (rbt),
        .stat_o  (act_settled)
    );

    // A module can show active only while its clock runs
    assign act_stat_o = act_settled & clk_stat_o;

    // R7
    reboot_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rbt != '0) |=> ((act_stat_o & $past(rbt)) == '0));

    // R7
    reboot_keep_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rbt != '0) |=> $stable(act_en_o));

endmodule

// File: tb/test_modgate_ctrl.sv
module test_modgate_ctrl;

    localparam int NUM_MOD = 24;
    localparam int SETTLE  = 6;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [7:0]         addr = '0;
    logic [31:0]        wdata = '0;
    logic               wr = 1'b0;
    logic               rd = 1'b0;
    logic [31:0]        rdata;
    logic [NUM_MOD-1:0] clk_en, act_en, clk_stat, act_stat;
    logic               hrst, cpu_half;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [7:0]  a;
        logic [31:0] exp;
        string       tag;
    } exp_item_t;

    exp_item_t sb_q[$];

    always #10 clk = ~clk;  // 50 MHz

    modgate_ctrl #(.NUM_MOD(NUM_MOD), .SETTLE(SETTLE), .ADDR_W(8)) i_modgate_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_i     (addr),
        .wdata_i    (wdata),
        .wr_i       (wr),
        .rd_i       (rd),
        .rdata_o    (rdata),
        .clk_en_o   (clk_en),
        .act_en_o   (act_en),
        .clk_stat_o (clk_stat),
        .act_stat_o (act_stat),
        .hrst_o     (hrst),
        .cpu_half_o (cpu_half)
    );

    // Monitor: pops one expected item for each read cycle
    always @(negedge clk) begin
        if (rd) begin
            if (sb_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL scoreboard: unexpected read at %h", addr);
            end else begin
                exp_item_t it;
                it = sb_q.pop_front();
                n_cmp++;
                if (rdata !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: read %h got %h expected %h", it.tag, it.a, rdata, it.exp);
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(posedge clk); #1;
        wr = 1'b0; wdata = '0;
    endtask

    task automatic rd_exp(input logic [7:0] a, input logic [31:0] e, input string tag);
        exp_item_t it;
        it.a = a; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        addr = a; rd = 1'b1;
        @(posedge clk); #1;
        rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state at the ports
        chk("R1 clk_en", 32'(clk_en), 0);
        chk("R1 act_stat", 32'(act_stat), 0);
        chk("R1 hrst", {31'd0, hrst}, 0);
        rst_n = 1'b1;
        idle(1);
        rd_exp(8'h00, 0, "R1");
        rd_exp(8'h04, 0, "R1");
        rd_exp(8'h20, 0, "R1");
        rd_exp(8'h24, 0, "R1");
        rd_exp(8'h40, 0, "R1");
        rd_exp(8'hC0, 0, "R1");

        // R2 / R3: set, exact settle timing
        wr_reg(8'h04, 32'h5);
        rd_exp(8'h04, 32'h5, "R2");
        rd_exp(8'h00, 32'h0, "R3");
        idle(SETTLE - 3);
        rd_exp(8'h00, 32'h0, "R3 early");
        rd_exp(8'h00, 32'h5, "R3 settled");

        wr_reg(8'h04, 32'hF0);
        rd_exp(8'h04, 32'hF5, "R2 zero bits keep");
        idle(SETTLE + 1);
        rd_exp(8'h00, 32'hF5, "R3");

        wr_reg(8'h08, 32'h11);
        rd_exp(8'h04, 32'hE4, "R2 clear");
        idle(SETTLE + 1);
        rd_exp(8'h00, 32'hE4, "R3 clear");
        rd_exp(8'h08, 32'h0, "R10 write-only");

        // R4 / R5 activation gated by clock status
        wr_reg(8'h24, 32'h105);
        rd_exp(8'h24, 32'h105, "R4");
        idle(SETTLE + 1);
        rd_exp(8'h20, 32'h004, "R5 gated");
        wr_reg(8'h04, 32'h101);
        idle(SETTLE + 1);
        rd_exp(8'h20, 32'h105, "R5");

        // R6 restart of the settle count
        wr_reg(8'h04, 32'h400);
        idle(2);
        wr_reg(8'h04, 32'h400);
        idle(SETTLE - 2);
        rd_exp(8'h00, 32'h1E5, "R6 restarted");
        rd_exp(8'h00, 32'h1E5, "R6 restarted");
        rd_exp(8'h00, 32'h5E5, "R6 settled");

        // R7 reboot of active bit 0, bit 1 not activated
        wr_reg(8'h2C, 32'h3);
        rd_exp(8'h20, 32'h104, "R7 dropped");
        rd_exp(8'h24, 32'h105, "R7 ctl kept");
        idle(SETTLE - 3);
        rd_exp(8'h20, 32'h104, "R7 still low");
        rd_exp(8'h20, 32'h105, "R7 back");
        rd_exp(8'h2C, 32'h0, "R10 write-only");

        // R8 host reset level
        wr_reg(8'hC0, 32'hFFFF_FFFF);
        chk("R8 hrst high", {31'd0, hrst}, 1);
        rd_exp(8'hC0, 32'h1, "R8");
        wr_reg(8'hC0, 32'h2);
        chk("R8 hrst low", {31'd0, hrst}, 0);
        rd_exp(8'hC0, 32'h0, "R8");

        // R9 CPU half-rate select
        wr_reg(8'h40, 32'h1);
        chk("R9 half", {31'd0, cpu_half}, 1);
        rd_exp(8'h40, 32'h1, "R9");
        wr_reg(8'h40, 32'h0);
        rd_exp(8'h40, 32'h0, "R9");

        // R10 unmapped writes change nothing, high bits read zero
        wr_reg(8'h10, 32'hFFFF_FFFF);
        idle(SETTLE + 1);
        rd_exp(8'h10, 32'h0, "R10 unmapped");
        rd_exp(8'h00, 32'h5E5, "R10 no effect");
        rd_exp(8'h24, 32'h105, "R10 no effect");
        addr = 8'h24;
        #1;
        chk("R10 rd low", rdata, 0);
        wr_reg(8'h04, 32'hFFFF_FFFF);
        rd_exp(8'h04, 32'h00FF_FFFF, "R10 width");

        // R4 deactivate
        wr_reg(8'h28, 32'h100);
        idle(SETTLE + 1);
        rd_exp(8'h20, 32'h005, "R4 deactivate");

        idle(2);
        chk("scoreboard drained", sb_q.size(), 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule